// File: doc/BRIEF.md
# Iterative Sine-Cosine Rotation Engine

This block computes the cosine and sine of a signed fixed-point angle using shift-and-add micro-rotations, and scales both by a signed modulus. One operation starts with a one-cycle start strobe. That strobe carries a function select, a precision code, the angle and the modulus. The engine returns a primary and a secondary result together with a one-cycle done pulse. The number of micro-rotations is four times the precision code, so a caller can trade latency for accuracy on each operation.

The angle is a signed q1.31 value that stands for θ/π, which covers the whole circle. Angles beyond ±π/2 are first folded by a half turn and the sign of the outputs is flipped at the end. An arctangent constant per rotation is derived at elaboration. A gain constant chosen for the rotation count cancels the CORDIC growth in the last step. The scaled results saturate instead of wrapping.

A small controller steps through three states: `ST_IDLE` waits for a start (transition `IDLE->ROTATE` on start), `ST_ROTATE` performs one micro-rotation per cycle (`ROTATE->ROTATE` while rotations remain, `ROTATE->SCALE` after the last one), and `ST_SCALE` applies gain and saturation and raises done (`SCALE->IDLE` unconditionally).

Top module: `sincos_rotor`

## Requirements
- R1: With function select 0, the primary result is m·cos(θ) and the secondary result is m·sin(θ), in q1.31, within the accuracy the rotation count allows.
- R2: With function select 1, the two results swap places: the primary result is m·sin(θ) and the secondary result is m·cos(θ).
- R3: An operation with precision code p performs 4·p micro-rotations. Done is high in the cycle that follows the (4·p+1)-th rising edge after the edge that accepts start.
- R4: Precision code 0 behaves exactly like code 1: it gives 4 rotations, the same latency and bit-identical results.
- R5: The angle word a stands for θ = a·π/2^31. All four quadrants give correctly signed results, including angles beyond ±π/2 that are folded internally.
- R6: Gain compensation is applied, so with 60 rotations the magnitude of the results matches |m| to within about 2^-22.
- R7: A result that would reach +1.0 or more is forced to 0x7FFFFFFF and never wraps to a negative value.
- R8: Done is a one-cycle pulse. Both results change only at the edge that raises done, and hold their values at all other times.
- R9: A start strobe that arrives while an operation is in progress is ignored. It changes neither the latency nor the results of the running operation.
- R10: During and after reset, done is low and both results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| func_i | input | 1 | 0: cosine primary, 1: sine primary |
| prec_i | input | PREC_W | Precision code, rotations = 4·code (0 taken as 1) |
| angle_i | input | DATA_W | Angle θ/π, signed q1.31 |
| modulus_i | input | DATA_W | Modulus m, signed q1.31 |
| res_primary_o | output | DATA_W | Primary result, q1.31 |
| res_secondary_o | output | DATA_W | Secondary result, q1.31 |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
For precision code p, done and both results are due 4·p+1 rising edges after the edge that takes start. This is 4·p+2 falling edges after start is driven. The bench drives start on a falling edge and counts falling edges until done appears, and it compares that count with the expected value. Results are read at that same falling edge. One falling edge later the bench checks that done has dropped and that the results have not moved. The ignored-start case injects a second strobe three cycles into a run and then applies the same latency and value checks to the first operation.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROTATE,
        ST_SCALE
    } phase_t;

    localparam real PI_R = 3.14159265358979323846;

    // arctan(2^-idx) expressed in units of pi, scaled by 2^frac
    function automatic longint atan_code(input int idx, input int frac);
        real r;
        r = $atan(2.0 ** (-idx)) / PI_R * (2.0 ** frac);
        return longint'(r);
    endfunction

    // reciprocal of the CORDIC growth after n rotations, scaled by 2^frac
    function automatic longint gain_code(input int n, input int frac);
        real k;
        k = 1.0;
        for (int i = 0; i < n; i++) begin
            k = k * $sqrt(1.0 + 2.0 ** (-2 * i));
        end
        return longint'((2.0 ** frac) / k);
    endfunction

endpackage

// File: rtl/sincos_ctrl.sv
module sincos_ctrl #(
    parameter int PREC_W        = 4,
    parameter int STEP_PER_CODE = 4,
    parameter int ITER_W        = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PREC_W-1:0] prec_i,
    output logic              load_o,
    output logic              step_o,
    output logic              finish_o,
    output logic [ITER_W-1:0] iter_o
);
    import sincos_pkg::*;

    phase_t            state_q, state_d;
    logic [ITER_W-1:0] iter_q, last_q;
    int                eff_code;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)          state_d = ST_ROTATE;
            ST_ROTATE: if (iter_q == last_q) state_d = ST_SCALE;
            ST_SCALE:                        state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    assign eff_code = (prec_i == '0) ? 1 : int'(prec_i);

    // rotation counter and its limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_q <= '0;
            last_q <= '0;
        end else if (load_o) begin
            iter_q <= '0;
            last_q <= ITER_W'(STEP_PER_CODE * eff_code - 1);
        end else if (step_o) begin
            iter_q <= iter_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_o   = 1'b0;
        step_o   = 1'b0;
        finish_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_o   = start_i;
            ST_ROTATE: step_o   = 1'b1;
            ST_SCALE:  finish_o = 1'b1;
            default:   ;
        endcase
    end

    assign iter_o = iter_q;

endmodule

// File: rtl/sincos_stage.sv
module sincos_stage #(
    parameter int DATA_W    = 32,
    parameter int EXT       = 40,
    parameter int MAX_ITER  = 60,
    parameter int ITER_W    = 6
) (
    input  logic signed [EXT-1:0]    x_i,
    input  logic signed [EXT-1:0]    y_i,
    input  logic signed [DATA_W-1:0] z_i,
    input  logic [ITER_W-1:0]        iter_i,
    output logic signed [EXT-1:0]    x_o,
    output logic signed [EXT-1:0]    y_o,
    output logic signed [DATA_W-1:0] z_o
);
    localparam int LUT_N = 2 ** ITER_W;

    logic [DATA_W-1:0] lut [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_lut
        localparam longint CODE = (g < MAX_ITER) ? sincos_pkg::atan_code(g, DATA_W - 1) : 64'sd0;
        assign lut[g] = DATA_W'(CODE);
    end

    logic signed [EXT-1:0]    x_sh, y_sh;
    logic signed [DATA_W-1:0] step_ang;
    logic                     turn_neg;

    always_comb begin
        x_sh     = x_i >>> iter_i;
        y_sh     = y_i >>> iter_i;
        step_ang = $signed(lut[iter_i]);
        turn_neg = z_i[DATA_W-1];
        if (turn_neg) begin
            x_o = x_i + y_sh;
            y_o = y_i - x_sh;
            z_o = z_i + step_ang;
        end else begin
            x_o = x_i - y_sh;
            y_o = y_i + x_sh;
            z_o = z_i - step_ang;
        end
    end

endmodule

// File: rtl/sincos_gain.sv
module sincos_gain #(
    parameter int DATA_W        = 32,
    parameter int EXT           = 40,
    parameter int GUARD         = 6,
    parameter int PREC_W        = 4,
    parameter int STEP_PER_CODE = 4
) (
    input  logic signed [EXT-1:0] v_i,
    input  logic                  neg_i,
    input  logic [PREC_W-1:0]     prec_i,
    output logic [DATA_W-1:0]     res_o
);
    localparam int K_W   = 32;
    localparam int PW    = EXT + 1 + K_W + 1;
    localparam int SH    = GUARD + K_W;
    localparam int NCODE = 2 ** PREC_W;
    localparam logic signed [PW-1:0] MAXV = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = ~MAXV;

    logic [K_W-1:0] ktab [NCODE];

    for (genvar c = 0; c < NCODE; c++) begin : g_gain
        localparam int     NROT = STEP_PER_CODE * ((c == 0) ? 1 : c);
        localparam longint KVAL = sincos_pkg::gain_code(NROT, K_W);
        assign ktab[c] = K_W'(KVAL);
    end

    logic signed [EXT:0]    v_ext;
    logic        [PW-1:0]   prod;
    logic signed [PW-1:0]   scaled;

    always_comb begin
        v_ext  = neg_i ? -{v_i[EXT-1], v_i} : {v_i[EXT-1], v_i};
        prod   = {{(PW-EXT-1){v_ext[EXT]}}, v_ext} * {{(PW-K_W){1'b0}}, ktab[prec_i]};
        scaled = $signed(prod) >>> SH;
        if (scaled > MAXV)      res_o = MAXV[DATA_W-1:0];
        else if (scaled < MINV) res_o = MINV[DATA_W-1:0];
        else                    res_o = scaled[DATA_W-1:0];
    end

endmodule

// File: rtl/sincos_rotor.sv
module sincos_rotor #(
    parameter int DATA_W        = 32,
    parameter int PREC_W        = 4,
    parameter int STEP_PER_CODE = 4,
    parameter int GUARD         = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              func_i,
    input  logic [PREC_W-1:0] prec_i,
    input  logic [DATA_W-1:0] angle_i,
    input  logic [DATA_W-1:0] modulus_i,
    output logic [DATA_W-1:0] res_primary_o,
    output logic [DATA_W-1:0] res_secondary_o,
    output logic              done_o
);
    localparam int MAX_ITER = STEP_PER_CODE * (2 ** PREC_W - 1);
    localparam int ITER_W   = $clog2(MAX_ITER + 1);
    localparam int EXT      = DATA_W + 2 + GUARD;

    logic              load_w, step_w, finish_w;
    logic [ITER_W-1:0] iter_w;

    sincos_ctrl #(
        .PREC_W(PREC_W), .STEP_PER_CODE(STEP_PER_CODE), .ITER_W(ITER_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .prec_i(prec_i),
        .load_o(load_w), .step_o(step_w), .finish_o(finish_w), .iter_o(iter_w)
    );

    logic signed [EXT-1:0]    x_q, y_q, x_n, y_n;
    logic signed [DATA_W-1:0] z_q, z_n;
    logic                     fold_q, func_q;
    logic [PREC_W-1:0]        prec_q;
    logic                     fold_in;
    logic [DATA_W-1:0]        cos_w, sin_w;

    assign fold_in = angle_i[DATA_W-1] ^ angle_i[DATA_W-2];

    sincos_stage #(
        .DATA_W(DATA_W), .EXT(EXT), .MAX_ITER(MAX_ITER), .ITER_W(ITER_W)
    ) u_stage (
        .x_i(x_q), .y_i(y_q), .z_i(z_q), .iter_i(iter_w),
        .x_o(x_n), .y_o(y_n), .z_o(z_n)
    );

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            fold_q <= 1'b0;
            func_q <= 1'b0;
            prec_q <= '0;
        end else if (load_w) begin
            x_q    <= {{2{modulus_i[DATA_W-1]}}, modulus_i, {GUARD{1'b0}}};
            y_q    <= '0;
            z_q    <= {angle_i[DATA_W-1] ^ fold_in, angle_i[DATA_W-2:0]};
            fold_q <= fold_in;
            func_q <= func_i;
            prec_q <= prec_i;
        end else if (step_w) begin
            x_q <= x_n;
            y_q <= y_n;
            z_q <= z_n;
        end
    end

    sincos_gain #(
        .DATA_W(DATA_W), .EXT(EXT), .GUARD(GUARD), .PREC_W(PREC_W), .STEP_PER_CODE(STEP_PER_CODE)
    ) u_gain_c (
        .v_i(x_q), .neg_i(fold_q), .prec_i(prec_q), .res_o(cos_w)
    );

    sincos_gain #(
        .DATA_W(DATA_W), .EXT(EXT), .GUARD(GUARD), .PREC_W(PREC_W), .STEP_PER_CODE(STEP_PER_CODE)
    ) u_gain_s (
        .v_i(y_q), .neg_i(fold_q), .prec_i(prec_q), .res_o(sin_w)
    );

    // result registers and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_primary_o   <= '0;
            res_secondary_o <= '0;
            done_o          <= 1'b0;
        end else begin
            done_o <= finish_w;
            if (finish_w) begin
                res_primary_o   <= func_q ? sin_w : cos_w;
                res_secondary_o <= func_q ? cos_w : sin_w;
            end
        end
    end

endmodule

// File: rtl/sincos_rotor_chk.sv
module sincos_rotor_chk #(
    parameter int DATA_W        = 32,
    parameter int PREC_W        = 4,
    parameter int STEP_PER_CODE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic [DATA_W-1:0] res_primary_o,
    input logic [DATA_W-1:0] res_secondary_o,
    input logic              load_i,
    input logic              step_i,
    input logic [PREC_W-1:0] prec_i
);
    logic [15:0] rot_cnt, rot_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rot_cnt <= '0;
            rot_exp <= '0;
        end else if (load_i) begin
            rot_cnt <= '0;
            rot_exp <= 16'(STEP_PER_CODE * ((prec_i == '0) ? 1 : int'(prec_i)));
        end else if (step_i) begin
            rot_cnt <= rot_cnt + 1'b1;
        end
    end

    // R3: rotation count matches the accepted precision code
    p_rot_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_i) |-> (rot_cnt == rot_exp));

    // R3: done follows the last rotation after exactly one scaling cycle
    p_done_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_i) |=> done_o);

    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: results only move together with done
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(res_primary_o) && $stable(res_secondary_o)));

    // R9: no new operation is loaded while rotating
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !load_i);

    // R10: reset clears done
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !done_o);

endmodule

bind sincos_rotor sincos_rotor_chk #(
    .DATA_W(DATA_W), .PREC_W(PREC_W), .STEP_PER_CODE(STEP_PER_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .done_o(done_o),
    .res_primary_o(res_primary_o), .res_secondary_o(res_secondary_o),
    .load_i(load_w), .step_i(step_w), .prec_i(prec_i)
);

// File: tb/sincos_rotor_tb.sv
module sincos_rotor_tb;
    localparam int  CLK_PERIOD = 10;
    localparam real PI_R       = 3.14159265358979323846;
    localparam real SC         = 2147483648.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        func = 1'b0;
    logic [3:0]  prec = '0;
    logic [31:0] angle = '0;
    logic [31:0] modu = '0;
    logic [31:0] res_p, res_s;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [31:0] last_p, last_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    sincos_rotor u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .func_i(func), .prec_i(prec),
        .angle_i(angle), .modulus_i(modu),
        .res_primary_o(res_p), .res_secondary_o(res_s), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint to_fix(input real v);
        real c;
        c = v * SC;
        if (c > SC - 1.0) c = SC - 1.0;
        if (c < -SC) c = -SC;
        return longint'(c);
    endfunction

    task automatic chk_val(input string req, input string what, input logic [31:0] got,
                           input real exp_r, input real tol);
        longint g, e, d;
        g = longint'($signed(got));
        e = to_fix(exp_r);
        d = (g > e) ? g - e : e - g;
        chk(real'(d) <= tol * SC, req, what, g, e);
    endtask

    // Runs one operation; optionally injects a stray start while busy (R9)
    task automatic run_op(input logic f, input logic [3:0] p, input logic [31:0] a,
                          input logic [31:0] m, input string req, input bit inject,
                          input real tol_fix);
        int n, k;
        real th, mr, c, s, tol;
        n = 4 * ((p == 0) ? 1 : int'(p));
        @(negedge clk);
        func = f; prec = p; angle = a; modu = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 200) begin
            if (inject && k == 3) begin
                start = 1'b1; func = ~f; prec = 4'd1; angle = ~a; modu = 32'h4000_0000;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        chk(k == n + 2, "R3", "latency in falling edges", k, n + 2);
        th  = real'($signed(a)) / SC * PI_R;
        mr  = real'($signed(m)) / SC;
        c   = mr * $cos(th);
        s   = mr * $sin(th);
        tol = (tol_fix > 0.0) ? tol_fix
              : 1.3 * (2.0 ** (-(n - 1))) * ((mr < 0.0) ? -mr : mr) + 2.0 ** (-22);
        if (f == 1'b0) begin
            chk_val(req, "primary (cos)", res_p, c, tol);
            chk_val(req, "secondary (sin)", res_s, s, tol);
        end else begin
            chk_val(req, "primary (sin)", res_p, s, tol);
            chk_val(req, "secondary (cos)", res_s, c, tol);
        end
        last_p = res_p;
        last_s = res_s;
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle", longint'(done), 0);
        chk(res_p == last_p && res_s == last_s, "R8", "results held",
            longint'(res_p), longint'(last_p));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] p1_p, p1_s;
        void'($urandom(32'd20240611));
        // R10: reset state
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done in reset", longint'(done), 0);
        chk(res_p == 0 && res_s == 0, "R10", "results in reset", longint'(res_p), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && res_p == 0, "R10", "state after reset", longint'(res_p), 0);

        // R1 / R2 directed
        run_op(1'b0, 4'd8, 32'h1555_5555, 32'h7FFF_FFFF, "R1", 1'b0, 0.0);
        run_op(1'b1, 4'd8, 32'h1555_5555, 32'h7FFF_FFFF, "R2", 1'b0, 0.0);
        run_op(1'b1, 4'd12, 32'hD000_0000, 32'hA000_0000, "R2", 1'b0, 0.0);

        // R5: all quadrants, including folded angles
        run_op(1'b0, 4'd10, 32'h6000_0000, 32'h6000_0000, "R5", 1'b0, 0.0);
        run_op(1'b0, 4'd10, 32'hA000_0000, 32'h6000_0000, "R5", 1'b0, 0.0);
        run_op(1'b1, 4'd10, 32'hC800_0000, 32'h6000_0000, "R5", 1'b0, 0.0);
        run_op(1'b0, 4'd10, 32'h4000_0001, 32'h7000_0000, "R5", 1'b0, 0.0);

        // R6: gain compensation at full precision
        run_op(1'b0, 4'd15, 32'h1000_0000, 32'h4000_0000, "R6", 1'b0, 2.0 ** (-22));
        run_op(1'b1, 4'd15, 32'hF000_0000, 32'h7FFF_FFFF, "R6", 1'b0, 2.0 ** (-22));

        // R7: result reaching +1.0 saturates without wrapping
        run_op(1'b0, 4'd15, 32'h8000_0000, 32'h8000_0000, "R7", 1'b0, 0.0);
        chk(res_p[31] == 1'b0, "R7", "no sign wrap", longint'(res_p), 32'h7FFF_FFFF);

        // R4: code 0 equals code 1
        run_op(1'b0, 4'd1, 32'h0C00_0000, 32'h5000_0000, "R4", 1'b0, 0.0);
        p1_p = last_p; p1_s = last_s;
        run_op(1'b0, 4'd0, 32'h0C00_0000, 32'h5000_0000, "R4", 1'b0, 0.0);
        chk(last_p == p1_p && last_s == p1_s, "R4", "code 0 matches code 1",
            longint'(last_p), longint'(p1_p));

        // R9: stray start while busy
        run_op(1'b0, 4'd6, 32'h2000_0000, 32'h7000_0000, "R9", 1'b1, 0.0);
        run_op(1'b1, 4'd2, 32'hE000_0000, 32'h3000_0000, "R9", 1'b1, 0.0);

        // Random mix (R1/R2/R3/R5)
        for (int i = 0; i < 40; i++) begin
            logic        rf;
            logic [3:0]  rp;
            logic [31:0] ra, rm;
            rf = 1'($urandom);
            rp = 4'($urandom_range(0, 15));
            ra = $urandom;
            rm = $urandom;
            run_op(rf, rp, ra, rm, rf ? "R2" : "R1", 1'b0, 0.0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule